// File: doc/BRIEF.md
# Modulo Up/Down Timer Counter

This block holds a 16-bit timer count that steps once for each counting-clock enable pulse. The count can run as a simple up counter. In that mode it wraps to zero after a terminal value, which is either the full 16-bit range or a programmed modulus. The count can also run as an up/down counter, the form used to build center-aligned PWM. In that form the count rises to the modulus, falls back to zero and rises again.

An overflow flag marks the end of every count period. A mask bit decides whether that flag also drives an interrupt request. Software reaches the block through a small 8-bit register port. A write to either half of the count restarts it from zero. Reading the high half first freezes the low half, so a 16-bit value can be read coherently as two byte reads.

Top module: `modtmr_top`

## Requirements
- R1: The count changes only in a cycle where `cnt_tick` is high or a clear takes effect. With the modulus register at 0x0000 and edge mode selected, the count runs 0x0000 up to 0xFFFF and then returns to 0x0000. That return sets the overflow flag.
- R2: In edge mode with a non-zero modulus M, the count runs 0 to M. The tick taken at M loads 0x0000 and sets the overflow flag. No other tick sets the flag.
- R3: In center mode (control bit 5 = 1) the count rises from 0 to the terminal value and then falls to 0, where it turns upward again. The terminal value and 0 each last one tick. The flag is set only by the tick that steps from the terminal value down to terminal-1.
- R4: The overflow flag (control bit 7) stays set until it is cleared. Clearing takes a read of address 0 while the flag is 1, followed by a write of address 0 with bit 7 = 0. A write that is not preceded by such a read leaves the flag set. If an overflow happens in the same cycle as the clearing write, the flag stays set.
- R5: `irq` is high exactly when the overflow flag and the enable bit (control bit 6) are both 1.
- R6: A write of any data to address 1 (count high) or address 2 (count low) sets the count to 0x0000 and the direction to up. This write takes priority over a tick in the same cycle.
- R7: A count write also discards any pending high-half read. The next read of address 2 then returns the live low byte.
- R8: A read of address 1 returns count[15:8] and freezes count[7:0]. The next read of address 2 returns the frozen byte and releases it. A read of address 2 with nothing frozen returns the live count[7:0].
- R9: A write to address 0 that changes bit 5 resets the count to 0x0000 and the direction to up.
- R10: The modulus is written and read back at address 3 (bits 15:8) and address 4 (bits 7:0). Reset clears the count, the modulus, the flag and both control bits. `bus_rdata` is 0 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counting-clock enable, one step per high cycle |
| bus_addr | input | 3 | Register address (0 ctrl, 1 count hi, 2 count lo, 3 mod hi, 4 mod lo) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address while `bus_rd` is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that the bus makes at most one access per cycle, so `bus_rd` and `bus_wr` are never high together. They also assume that a changed modulus is not smaller than the count currently held. The bench issues each register access as its own one-cycle transaction. It writes the modulus only after a count clear, or while the count is still below the new value. The one case where ticks and a bus write share a cycle, the same-cycle clear and overflow, is driven on purpose, because R4 and R6 define its outcome.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = CNT_W / 2;

  localparam int A_CTRL   = 0;
  localparam int A_CNT_HI = 1;
  localparam int A_CNT_LO = 2;
  localparam int A_MOD_HI = 3;
  localparam int A_MOD_LO = 4;

  localparam int B_FLAG   = 7;
  localparam int B_IE     = 6;
  localparam int B_CENTER = 5;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             down;
    logic             ovf;
  } step_t;

  // a zero modulus selects the full range
  function automatic logic [CNT_W-1:0] term_of(input logic [CNT_W-1:0] modv);
    return (modv == '0) ? '1 : modv;
  endfunction

  function automatic step_t next_step(input logic [CNT_W-1:0] c,
                                      input logic             dn,
                                      input logic [CNT_W-1:0] t,
                                      input logic             ctr);
    step_t s;
    s.cnt  = c;
    s.down = dn;
    s.ovf  = 1'b0;
    if (!ctr) begin
      s.down = 1'b0;
      if (c == t) begin
        s.cnt = '0;
        s.ovf = 1'b1;
      end else begin
        s.cnt = c + 1'b1;
      end
    end else if (!dn) begin
      if (c == t) begin
        s.cnt  = c - 1'b1;
        s.down = 1'b1;
        s.ovf  = 1'b1;
      end else begin
        s.cnt = c + 1'b1;
      end
    end else begin
      if (c == '0) begin
        s.cnt  = c + 1'b1;
        s.down = 1'b0;
      end else begin
        s.cnt = c - 1'b1;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/modtmr_core.sv
module modtmr_core
  import modtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             center,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt,
  output logic             down,
  output logic             ovf_evt
);
  step_t nxt;

  always_comb nxt = next_step(cnt, down, term, center);

  assign ovf_evt = tick & ~clr & nxt.ovf;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      cnt  <= nxt.cnt;
      down <= nxt.down;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> ($stable(cnt) && $stable(down))); // R1
  AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !center && cnt == term) |=> (cnt == '0)); // R2
  AST_CENTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && center && !down && cnt == term) |=> (down && cnt == $past(term) - 1'b1)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !down)); // R6
endmodule

// File: rtl/modtmr_flag.sv
module modtmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic rd_ctrl,
  input  logic wr_ctrl,
  input  logic wr_flag_bit,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (wr_ctrl) begin
      armed <= 1'b0;
    end else if (rd_ctrl && flag) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (ovf_evt) begin
      flag <= 1'b1;
    end else if (wr_ctrl && armed && !wr_flag_bit) begin
      flag <= 1'b0;
    end
  end

  assign irq = flag & irq_en;

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag); // R4
  AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag); // R4
endmodule

// File: rtl/modtmr_rdhold.sv
module modtmr_rdhold
  import modtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              cnt_wr,
  input  logic [BYTE_W-1:0] live_lo,
  output logic [BYTE_W-1:0] lo_out,
  output logic              held_valid
);
  logic [BYTE_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_wr) begin
      held_valid <= 1'b0;
    end else if (rd_hi) begin
      held_valid <= 1'b1;
    end else if (rd_lo) begin
      held_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else if (rd_hi && !cnt_wr) held <= live_lo;
  end

  assign lo_out = held_valid ? held : live_lo;

  AST_WRITE_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !held_valid); // R7
  AST_HI_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !cnt_wr) |=> (held_valid && lo_out == $past(live_lo))); // R8
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  logic             ie_q, center_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] cnt;
  logic             down, ovf_evt, flag;
  logic [BYTE_W-1:0] lo_out;
  logic             held_valid;

  logic sel_ctrl, sel_chi, sel_clo, sel_mhi, sel_mlo;
  logic cnt_wr, mode_chg, clr;

  assign sel_ctrl = (bus_addr == ADDR_W'(A_CTRL));
  assign sel_chi  = (bus_addr == ADDR_W'(A_CNT_HI));
  assign sel_clo  = (bus_addr == ADDR_W'(A_CNT_LO));
  assign sel_mhi  = (bus_addr == ADDR_W'(A_MOD_HI));
  assign sel_mlo  = (bus_addr == ADDR_W'(A_MOD_LO));

  assign cnt_wr   = bus_wr & (sel_chi | sel_clo);
  assign mode_chg = bus_wr & sel_ctrl & (bus_wdata[B_CENTER] != center_q);
  assign clr      = cnt_wr | mode_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      center_q <= 1'b0;
      mod_q    <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) begin
        ie_q     <= bus_wdata[B_IE];
        center_q <= bus_wdata[B_CENTER];
      end
      if (sel_mhi) mod_q[CNT_W-1:BYTE_W] <= bus_wdata;
      if (sel_mlo) mod_q[BYTE_W-1:0]     <= bus_wdata;
    end
  end

  modtmr_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_tick),
    .clr     (clr),
    .center  (center_q),
    .term    (term_of(mod_q)),
    .cnt     (cnt),
    .down    (down),
    .ovf_evt (ovf_evt)
  );

  modtmr_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovf_evt     (ovf_evt),
    .rd_ctrl     (bus_rd & sel_ctrl),
    .wr_ctrl     (bus_wr & sel_ctrl),
    .wr_flag_bit (bus_wdata[B_FLAG]),
    .irq_en      (ie_q),
    .flag        (flag),
    .irq         (irq)
  );

  modtmr_rdhold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_hi      (bus_rd & sel_chi),
    .rd_lo      (bus_rd & sel_clo),
    .cnt_wr     (cnt_wr),
    .live_lo    (cnt[BYTE_W-1:0]),
    .lo_out     (lo_out),
    .held_valid (held_valid)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ctrl) begin
        bus_rdata[B_FLAG]   = flag;
        bus_rdata[B_IE]     = ie_q;
        bus_rdata[B_CENTER] = center_q;
      end
      if (sel_chi) bus_rdata = cnt[CNT_W-1:BYTE_W];
      if (sel_clo) bus_rdata = lo_out;
      if (sel_mhi) bus_rdata = mod_q[CNT_W-1:BYTE_W];
      if (sel_mlo) bus_rdata = mod_q[BYTE_W-1:0];
    end
  end

  AST_MODE_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt == '0 && !down && !held_valid == !held_valid)); // R9
  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag)) |-> $past(ovf_evt)); // R4
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/modtmr_top_test.sv
module modtmr_top_test;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_NS/2) clk = ~clk;

  modtmr_top uut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        center;
    logic [15:0] modv;
    logic [15:0] ticks;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd0, 16'd5, 16'd5, 1'b0},   // R1
    '{1'b0, 16'd4, 16'd5, 16'd0, 1'b1},   // R2
    '{1'b0, 16'd4, 16'd7, 16'd2, 1'b1},   // R2
    '{1'b0, 16'd4, 16'd4, 16'd4, 1'b0},   // R2
    '{1'b1, 16'd3, 16'd3, 16'd3, 1'b0},   // R3
    '{1'b1, 16'd3, 16'd4, 16'd2, 1'b1},   // R3
    '{1'b1, 16'd3, 16'd6, 16'd0, 1'b1},   // R3
    '{1'b1, 16'd3, 16'd7, 16'd1, 1'b1},   // R3
    '{1'b1, 16'd3, 16'd9, 16'd3, 1'b1},   // R3
    '{1'b1, 16'd1, 16'd2, 16'd0, 1'b1}    // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_with_tick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; cnt_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cnt_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      cnt_tick = 1'b1;
      repeat (n) @(negedge clk);
      cnt_tick = 1'b0;
    end
  endtask

  task automatic read_cnt(output logic [15:0] c);
    logic [7:0] h, l;
    rd(3'd1, h);
    rd(3'd2, l);
    c = {h, l};
  endtask

  task automatic setup(input logic center, input logic ie, input logic [15:0] m);
    logic [7:0] dummy;
    rd(3'd0, dummy);
    wr(3'd0, {1'b0, ie, center, 5'b0});
    wr(3'd3, m[15:8]);
    wr(3'd4, m[7:0]);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] c;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R10
    rd(3'd0, v);  check("R10 ctrl reset", v, 8'h00);
    read_cnt(c);  check("R10 count reset", c, 16'h0000);
    rd(3'd3, v);  check("R10 mod hi reset", v, 8'h00);
    check("R5 irq reset", irq, 1'b0);
    #1 check("R10 idle rdata", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].center, 1'b0, VECS[i].modv);
      ticks(int'(VECS[i].ticks));
      read_cnt(c);
      check(VECS[i].center ? "R3 table count" : "R2 table count", c, VECS[i].exp_cnt);
      rd(3'd0, v);
      check(VECS[i].center ? "R3 table flag" : "R2 table flag", v[7], VECS[i].exp_flag);
    end

    // R10 modulus readback
    setup(1'b0, 1'b0, 16'hA55C);
    rd(3'd3, v); check("R10 mod hi", v, 8'hA5);
    rd(3'd4, v); check("R10 mod lo", v, 8'h5C);

    // R1 free run through full range
    setup(1'b0, 1'b0, 16'h0000);
    ticks(65535);
    read_cnt(c); check("R1 at top", c, 16'hFFFF);
    rd(3'd0, v); check("R1 no flag at top", v[7], 1'b0);
    repeat (5) @(negedge clk);
    read_cnt(c); check("R1 hold without tick", c, 16'hFFFF);
    ticks(1);
    read_cnt(c); check("R1 wrap", c, 16'h0000);
    rd(3'd0, v); check("R1 wrap flag", v[7], 1'b1);

    // R4 clear protocol and R5 irq mask
    setup(1'b0, 1'b0, 16'd2);
    ticks(3);
    wr(3'd0, 8'h00);
    rd(3'd0, v); check("R4 blind write keeps flag", v[7], 1'b1);
    check("R5 masked irq", irq, 1'b0);
    wr(3'd0, 8'hC0);
    check("R5 enabled irq", irq, 1'b1);
    rd(3'd0, v);
    wr(3'd0, 8'h40);
    rd(3'd0, v); check("R4 armed clear", v[7], 1'b0);
    check("R5 irq drops with flag", irq, 1'b0);
    // same-cycle overflow and clear: count 0 -> tick to 2, set flag first
    wr(3'd1, 8'h00);
    ticks(3);
    rd(3'd0, v);
    ticks(2);
    wr_with_tick(3'd0, 8'h40);
    rd(3'd0, v); check("R4 overflow beats clear", v[7], 1'b1);
    read_cnt(c); check("R4 wrap on clear cycle", c, 16'h0000);

    // R6 count write beats tick
    ticks(1);
    wr_with_tick(3'd2, 8'h77);
    read_cnt(c); check("R6 write over tick", c, 16'h0000);

    // R8 coherent byte read
    setup(1'b0, 1'b0, 16'h0000);
    ticks(308);
    rd(3'd1, v); check("R8 high byte", v, 8'h01);
    ticks(5);
    rd(3'd2, v); check("R8 frozen low", v, 8'h34);
    rd(3'd2, v); check("R8 live low after release", v, 8'h39);

    // R7 count write drops frozen byte
    rd(3'd1, v);
    wr(3'd2, 8'hFF);
    ticks(3);
    rd(3'd2, v); check("R7 live low after write", v, 8'h03);

    // R9 mode switch clears count and direction
    setup(1'b1, 1'b0, 16'd5);
    ticks(7);
    read_cnt(c); check("R3 descending", c, 16'd3);
    wr(3'd0, 8'h00);
    read_cnt(c); check("R9 switch to edge clears", c, 16'd0);
    ticks(2);
    read_cnt(c); check("R9 counts up after switch", c, 16'd2);
    wr(3'd0, 8'h20);
    ticks(1);
    read_cnt(c); check("R9 center restarts upward", c, 16'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule